// File: doc/BRIEF.md
# Lane Drive Level Adjuster

During link training, the transmitter reads the receiver's adjust-request status once per loop iteration. This block turns those requests into the drive settings the transmitter applies and writes back. The inputs are two request bytes that hold one 4-bit nibble per lane, an optional post-cursor2 request byte, the number of active lanes and a post-cursor2 enable. When `calc_i` is strobed, the block clamps every lane's request to its legal limits and raises the max-reached flags. It then registers four outputs:

- the per-lane training-set bytes that go back to the receiver;
- the packed post-cursor2 set bytes;
- the plain level codes that drive the analog output stage;
- a one-cycle `done_o`.

The voltage-swing ceiling is not fixed. It shrinks as pre-emphasis grows. A pre-emphasis request at its top level pins pre-emphasis at 3 and forces swing to 0, and both fields carry the max-reached flag. The outputs hold their values between strobes.

Top module: `lda_drive_adjust`

## Requirements
- R1: The request for lane i is the nibble at bits [8*(i/2)+4*(i%2) +: 4] of `adj_req_i`, so even lanes use the low nibble of a byte and odd lanes the high nibble. Within a nibble, bits 1:0 are the swing request and bits 3:2 are the pre-emphasis request.
- R2: A pre-emphasis request of 3 yields a pre-emphasis field of 3'b111 (level 3 with the flag in bit 2) and a swing field of 3'b100 (level 0 with the flag), so the training-set byte is 8'h3C.
- R3: For pre-emphasis p < 3 and swing request s >= 3-p, the swing field becomes (3-p) with the flag in bit 2.
- R4: For pre-emphasis p < 3 and swing request s < 3-p, both fields pass the request levels through with no flag.
- R5: An active lane's training-set byte is {2'b00, pre-emphasis field[2:0], swing field[2:0]}, which is the pre-emphasis field shifted left by 3 ORed with the swing field. Lane i occupies `tset_o[8*i +: 8]`.
- R6: The post-cursor2 request for lane i is `pc2_req_i[2*i +: 2]`. A request of 3 becomes 3'b111 (level 3 with the flag in bit 2), and lower requests pass through unchanged.
- R7: Lane i's 4-bit post-cursor2 value sits at `pc2set_o[4*i +: 4]`, so each byte holds two lanes with the even lane in the low nibble.
- R8: With `pc2_en_i` low, `pc2set_o` and `pc2_o` are zero.
- R9: A lane with index >= `lane_cnt_i` outputs zero in its training-set byte, its post-cursor2 nibble and its three drive codes.
- R10: The outputs update on the clock edge where `calc_i` is high, and `done_o` is high for exactly the following cycle. Without `calc_i` the outputs keep their values.
- R11: While reset is held (active-low `rst_n`), every output is zero.
- R12: The drive codes `swing_o[2*i +: 2]`, `pre_o[2*i +: 2]` and `pc2_o[2*i +: 2]` carry the clamped levels without flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_i | input | 1 | Compute strobe |
| adj_req_i | input | 8*((LANES+1)/2) (16) | Adjust-request bytes, one nibble per lane |
| pc2_req_i | input | 2*LANES (8) | Post-cursor2 requests, 2 bits per lane |
| lane_cnt_i | input | $clog2(LANES+1) (3) | Number of active lanes |
| pc2_en_i | input | 1 | Post-cursor2 handling enable |
| done_o | output | 1 | One-cycle pulse after a computation |
| tset_o | output | 8*LANES (32) | Per-lane training-set bytes |
| pc2set_o | output | 4*LANES (16) | Packed post-cursor2 set values |
| swing_o | output | 2*LANES (8) | Per-lane swing level code |
| pre_o | output | 2*LANES (8) | Per-lane pre-emphasis level code |
| pc2_o | output | 2*LANES (8) | Per-lane post-cursor2 level code |

## Verification
The bench builds the block with its default of LANES = 4, the widest case. At that width the request nibbles fill both the low and high halves of both request bytes, and the post-cursor2 output fills both bytes. It sweeps all 16 request nibbles on every lane, which covers each branch of the clamping rule. It also drives lane counts of 1, 2 and 4, so the upper lanes are masked in different amounts.

// File: rtl/lda_pkg.sv
package lda_pkg;

  // Fold a 4-bit lane request into {pre_field[2:0], swing_field[2:0]}.
  // Bit 2 of each field is the max-reached flag.
  function automatic logic [5:0] fold_req(input logic [3:0] nib);
    logic [1:0] pe;
    logic [1:0] sw;
    logic [1:0] lim;
    pe  = nib[3:2];
    sw  = nib[1:0];
    lim = 2'd3 - pe;
    if (pe == 2'd3)
      return {3'b111, 3'b100};
    else if (sw >= lim)
      return {1'b0, pe, 1'b1, lim};
    else
      return {1'b0, pe, 1'b0, sw};
  endfunction

  // Fold a 2-bit post-cursor2 request into a 3-bit field with flag.
  function automatic logic [2:0] fold_pc2(input logic [1:0] req);
    if (req == 2'd3)
      return 3'b111;
    else
      return {1'b0, req};
  endfunction

endpackage

// File: rtl/lda_lane.sv
module lda_lane
  import lda_pkg::*;
(
  input  logic [3:0] req_nib,
  input  logic [1:0] pc2_req,
  input  logic       active,
  input  logic       pc2_en,
  output logic [7:0] tset,
  output logic [3:0] pc2_nib,
  output logic [1:0] sw_lvl,
  output logic [1:0] pe_lvl,
  output logic [1:0] pc_lvl
);

  logic [5:0] fields;
  logic [2:0] pcf;
  logic       pc_on;

  always_comb begin
    fields  = fold_req(req_nib);
    pcf     = fold_pc2(pc2_req);
    pc_on   = active && pc2_en;
    tset    = active ? {2'b00, fields} : 8'h00;
    sw_lvl  = active ? fields[1:0] : 2'b00;
    pe_lvl  = active ? fields[4:3] : 2'b00;
    pc2_nib = pc_on ? {1'b0, pcf} : 4'h0;
    pc_lvl  = pc_on ? pcf[1:0] : 2'b00;
  end

endmodule

// File: rtl/lda_stage.sv
module lda_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/lda_drive_adjust.sv
module lda_drive_adjust #(
  parameter  int LANES = 4,
  localparam int BYTES = (LANES + 1) / 2,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calc_i,
  input  logic [8*BYTES-1:0]   adj_req_i,
  input  logic [2*LANES-1:0]   pc2_req_i,
  input  logic [CNT_W-1:0]     lane_cnt_i,
  input  logic                 pc2_en_i,
  output logic                 done_o,
  output logic [8*LANES-1:0]   tset_o,
  output logic [4*LANES-1:0]   pc2set_o,
  output logic [2*LANES-1:0]   swing_o,
  output logic [2*LANES-1:0]   pre_o,
  output logic [2*LANES-1:0]   pc2_o
);

  localparam int STW = 8*LANES + 4*LANES + 6*LANES;

  logic [LANES-1:0]   lane_act_w;
  logic [8*LANES-1:0] tset_w;
  logic [4*LANES-1:0] pc2set_w;
  logic [2*LANES-1:0] swing_w;
  logic [2*LANES-1:0] pre_w;
  logic [2*LANES-1:0] pc2_w;
  logic [STW-1:0]     stage_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_act_w[g] = lane_cnt_i > CNT_W'(g);

    lda_lane u_lane (
      .req_nib (adj_req_i[8*(g/2) + 4*(g%2) +: 4]),
      .pc2_req (pc2_req_i[2*g +: 2]),
      .active  (lane_act_w[g]),
      .pc2_en  (pc2_en_i),
      .tset    (tset_w[8*g +: 8]),
      .pc2_nib (pc2set_w[4*g +: 4]),
      .sw_lvl  (swing_w[2*g +: 2]),
      .pe_lvl  (pre_w[2*g +: 2]),
      .pc_lvl  (pc2_w[2*g +: 2])
    );
  end

  lda_stage #(.W(STW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (calc_i),
    .d     ({tset_w, pc2set_w, swing_w, pre_w, pc2_w}),
    .q     (stage_q),
    .pulse (done_o)
  );

  assign {tset_o, pc2set_o, swing_o, pre_o, pc2_o} = stage_q;

endmodule

// File: rtl/lda_chk.sv
module lda_chk #(
  parameter  int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 calc_i,
  input logic                 pc2_en_i,
  input logic [LANES-1:0]     lane_act_w,
  input logic                 done_o,
  input logic [8*LANES-1:0]   tset_o,
  input logic [4*LANES-1:0]   pc2set_o,
  input logic [2*LANES-1:0]   swing_o,
  input logic [2*LANES-1:0]   pre_o,
  input logic [2*LANES-1:0]   pc2_o
);

  AST_DONE_AFTER_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    calc_i |=> done_o); // R10

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_i |=> !done_o); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_i |=> ($stable(tset_o) && $stable(pc2set_o) && $stable(swing_o))); // R10

  AST_PC2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(pc2_en_i)) |-> (pc2set_o == '0 && pc2_o == '0)); // R8

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_SWING_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, swing_o[2*g +: 2]} + {1'b0, pre_o[2*g +: 2]}) <= 3'd3); // R3

    AST_PRE_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tset_o[8*g+5] |-> (tset_o[8*g+3 +: 2] == 2'b11 && tset_o[8*g +: 3] == 3'b100)); // R2

    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(lane_act_w[g])) |-> (tset_o[8*g +: 8] == 8'h00)); // R9

    AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (swing_o[2*g +: 2] == tset_o[8*g +: 2] &&
                  pre_o[2*g +: 2] == tset_o[8*g+3 +: 2])); // R12
  end

endmodule

bind lda_drive_adjust lda_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .calc_i     (calc_i),
  .pc2_en_i   (pc2_en_i),
  .lane_act_w (lane_act_w),
  .done_o     (done_o),
  .tset_o     (tset_o),
  .pc2set_o   (pc2set_o),
  .swing_o    (swing_o),
  .pre_o      (pre_o),
  .pc2_o      (pc2_o)
);

// File: tb/sim_lda_drive_adjust.sv
`timescale 1ns/1ps
module sim_lda_drive_adjust;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        calc_i = 1'b0;
  logic [15:0] adj_req_i = '0;
  logic [7:0]  pc2_req_i = '0;
  logic [2:0]  lane_cnt_i = 3'd4;
  logic        pc2_en_i = 1'b0;
  logic        done_o;
  logic [31:0] tset_o;
  logic [15:0] pc2set_o;
  logic [7:0]  swing_o, pre_o, pc2_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lda_drive_adjust u0 (
    .clk(clk), .rst_n(rst_n), .calc_i(calc_i), .adj_req_i(adj_req_i),
    .pc2_req_i(pc2_req_i), .lane_cnt_i(lane_cnt_i), .pc2_en_i(pc2_en_i),
    .done_o(done_o), .tset_o(tset_o), .pc2set_o(pc2set_o),
    .swing_o(swing_o), .pre_o(pre_o), .pc2_o(pc2_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model of one lane: returns {swing_lvl, pre_lvl, tset byte}.
  function automatic logic [11:0] model_lane(input logic [3:0] nib);
    int p, s, sl, pl;
    logic [7:0] b;
    p = int'(nib[3:2]);
    s = int'(nib[1:0]);
    if (p >= 3) begin
      b = 8'h3C; sl = 0; pl = 3;
    end else if (s + p >= 3) begin
      sl = 3 - p; pl = p;
      b = 8'(p * 8 + 4 + sl);
    end else begin
      sl = s; pl = p;
      b = 8'(p * 8 + s);
    end
    return {2'(sl), 2'(pl), b};
  endfunction

  task automatic check_all(input logic [15:0] adj, input logic [7:0] pr,
                           input int cnt, input bit en, input string tag);
    logic [31:0] et = '0;
    logic [15:0] ep = '0;
    logic [7:0]  es = '0, ee = '0, ec = '0;
    for (int i = 0; i < 4; i++) begin
      logic [3:0]  nib;
      logic [11:0] m;
      int r;
      nib = (i % 2 == 0) ? adj[8*(i/2) +: 4] : adj[8*(i/2)+4 +: 4];
      m = model_lane(nib);
      r = int'(pr[2*i +: 2]);
      if (i < cnt) begin
        et[8*i +: 8] = m[7:0];
        es[2*i +: 2] = m[11:10];
        ee[2*i +: 2] = m[9:8];
        if (en) begin
          ep[4*i +: 4] = (r == 3) ? 4'h7 : 4'(r);
          ec[2*i +: 2] = 2'(r);
        end
      end
    end
    chk(tset_o == et, {tag, " tset R1 R5 R9"}, tset_o, et);
    chk(pc2set_o == ep, {tag, " pc2set R6 R7 R8"}, 32'(pc2set_o), 32'(ep));
    chk(swing_o == es, {tag, " swing R12"}, 32'(swing_o), 32'(es));
    chk(pre_o == ee, {tag, " pre R12"}, 32'(pre_o), 32'(ee));
    chk(pc2_o == ec, {tag, " pc2 R12"}, 32'(pc2_o), 32'(ec));
  endtask

  task automatic apply(input logic [15:0] adj, input logic [7:0] pr,
                       input int cnt, input bit en, input string tag);
    @(negedge clk);
    adj_req_i = adj; pc2_req_i = pr; lane_cnt_i = 3'(cnt); pc2_en_i = en;
    calc_i = 1'b1;
    @(negedge clk);
    calc_i = 1'b0;
    chk(done_o == 1'b1, {tag, " done pulse R10"}, 32'(done_o), 32'd1);
    check_all(adj, pr, cnt, en, tag);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " done single cycle R10"}, 32'(done_o), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(done_o == 1'b0 && tset_o == '0 && pc2set_o == '0 &&
        swing_o == '0 && pre_o == '0 && pc2_o == '0,
        "reset state R11", tset_o, 32'd0);
  endtask

  task automatic t_mapping;
    // lane0 nib 1, lane1 nib 4, lane2 nib 2, lane3 nib 8
    apply(16'h8241, 8'h00, 4, 1'b0, "mapping R1 R4");
    apply(16'h1482, 8'h00, 4, 1'b0, "mapping swapped R1");
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 16; n++)
      apply({4{4'(n)}}, 8'h00, 4, 1'b0, $sformatf("sweep nib %0d R2 R3 R4", n));
  endtask

  task automatic t_pc2;
    apply(16'h0000, 8'hE4, 4, 1'b1, "pc2 levels R6 R7");
    apply(16'h0000, 8'h1B, 4, 1'b1, "pc2 reversed R6 R7");
    apply(16'h5A5A, 8'hFF, 4, 1'b0, "pc2 disabled R8");
  endtask

  task automatic t_lanes;
    apply(16'h5A5A, 8'hFF, 1, 1'b1, "one lane R9");
    apply(16'h3C3C, 8'hE4, 2, 1'b1, "two lanes R9");
    apply(16'hFFFF, 8'hFF, 0, 1'b1, "zero lanes R9");
  endtask

  task automatic t_hold;
    logic [31:0] t0;
    apply(16'h2109, 8'h39, 4, 1'b1, "hold setup R10");
    t0 = tset_o;
    @(negedge clk);
    adj_req_i = 16'hFFFF; pc2_req_i = 8'h00; lane_cnt_i = 3'd1; pc2_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(tset_o == t0 && done_o == 1'b0, "hold without strobe R10", tset_o, t0);
    check_all(16'h2109, 8'h39, 4, 1'b1, "hold outputs R10");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R10: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mapping();
    t_sweep();
    t_pc2();
    t_lanes();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule